// File: doc/BRIEF.md
# Deferred-Flag Condition Evaluator

This block decides, cycle by cycle, whether an instruction may execute. It does not keep NZCV flag bits. Instead, each flag-setting ALU operation leaves behind a pair of 32-bit operands and a tag for the kind of comparison. The tag is an arithmetic compare, an XOR test or an AND test. When a later instruction presents its 4-bit condition field, the block evaluates that field against the saved pair. The result is either an execute decision or an undefined-instruction trap.

The datapath reports each completed flag-setting operation by pulsing `upd_valid_i`. With that pulse it gives the opcode, both ALU operands and the ALU result. The block latches the pair that the opcode calls for, and the new pair is visible to the condition check one cycle later. Opcodes that carry or borrow in (add-with-carry, subtract-with-carry and reverse-subtract-with-carry) cannot be expressed this way. For these the block raises a separate trap and leaves the saved state untouched.

Top module: `dfc_cond_unit`

## Requirements
- R1: The condition field is instruction bits 31:28. No other instruction bit affects `exec_o` or `trap_o`.
- R2: After reset the kind is arithmetic compare and both saved operands are zero. Code 0 therefore executes, code 1 does not, code 2 executes and code 3 does not.
- R3: Under the arithmetic kind with saved pair (a, b), the unsigned and equality codes behave as follows. Code 0 executes when a == b and code 1 when a != b. Code 2 executes when a >= b unsigned and code 3 when a < b unsigned. Code 8 executes when a > b unsigned and code 9 when a <= b unsigned.
- R4: Under the arithmetic kind, the signed codes behave as follows. Code 4 executes when bit 31 of (a − b mod 2^32) is 1 and code 5 when it is 0. Codes 10, 11, 12 and 13 execute when a >= b, a < b, a > b and a <= b respectively, with a and b read as two's complement.
- R5: Code 14 always executes and code 15 never executes, under every kind. Neither code traps.
- R6: Under the arithmetic kind, codes 6 and 7 raise `trap_o`. Whenever `trap_o` is 1, `exec_o` is 0.
- R7: Opcode 8 selects the AND-test kind on (op1, op2), and opcode 9 selects the XOR-test kind on (op1, op2). Under these kinds, codes 0 and 1 execute when the combined value is zero and non-zero respectively. Codes 4 and 5 execute when its bit 31 is 1 and 0 respectively. Every code other than 0, 1, 4, 5, 14 and 15 traps.
- R8: Opcodes 2 and 10 save the pair (op1, op2) under the arithmetic kind. Opcode 3 saves the pair (op2, op1).
- R9: Opcode 4 saves the pair (op2, −op1) and opcode 11 saves the pair (op1, −op2), both under the arithmetic kind.
- R10: Opcodes 0, 1, 12, 13, 14 and 15 save the pair (result, 0) under the arithmetic kind.
- R11: Opcodes 5, 6 and 7 with `upd_valid_i` high drive `upd_trap_o` high in the same cycle and leave the saved kind and pair unchanged. `upd_trap_o` is low whenever `upd_valid_i` is low.
- R12: The saved state is registered. A condition check in the cycle after an update sees the new pair and kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction whose condition field is evaluated |
| upd_valid_i | input | 1 | A flag-setting operation completes this cycle |
| upd_op_i | input | 4 | ALU opcode of that operation |
| upd_op1_i | input | 32 | First ALU operand |
| upd_op2_i | input | 32 | Second ALU operand |
| upd_res_i | input | 32 | ALU result |
| exec_o | output | 1 | Instruction executes |
| trap_o | output | 1 | Condition code is unsupported for the saved kind |
| upd_trap_o | output | 1 | Update opcode is unsupported (carry-in forms) |

## Verification
The bench builds the block with its default parameters: a 32-bit data width and the condition field at bit 28. These values bring the sign boundary 0x7fffffff/0x80000000 and the all-ones value within reach of the operand picker. Wraparound in the negated captures, and the points where signed and unsigned orderings disagree, are therefore hit often. After every update, all sixteen condition codes are swept while random bits fill the rest of the instruction.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  typedef enum logic [1:0] {
    KIND_ARITH = 2'd0,
    KIND_XOR   = 2'd1,
    KIND_AND   = 2'd2
  } cmp_kind_e;

  // opcode values are decoded from the instruction, keep them fixed
  localparam logic [3:0] OP_AND = 4'd0;
  localparam logic [3:0] OP_EOR = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_RSB = 4'd3;
  localparam logic [3:0] OP_ADD = 4'd4;
  localparam logic [3:0] OP_ADC = 4'd5;
  localparam logic [3:0] OP_SBC = 4'd6;
  localparam logic [3:0] OP_RSC = 4'd7;
  localparam logic [3:0] OP_TST = 4'd8;
  localparam logic [3:0] OP_TEQ = 4'd9;
  localparam logic [3:0] OP_CMP = 4'd10;
  localparam logic [3:0] OP_CMN = 4'd11;
  localparam logic [3:0] OP_ORR = 4'd12;
  localparam logic [3:0] OP_MOV = 4'd13;
  localparam logic [3:0] OP_BIC = 4'd14;
  localparam logic [3:0] OP_MVN = 4'd15;

  localparam int COND_W = 4;
endpackage

// File: rtl/dfc_capture.sv
module dfc_capture
  import dfc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  input  logic [3:0]        upd_op_i,
  input  logic [DATA_W-1:0] upd_op1_i,
  input  logic [DATA_W-1:0] upd_op2_i,
  input  logic [DATA_W-1:0] upd_res_i,
  output logic [DATA_W-1:0] cc_a_o,
  output logic [DATA_W-1:0] cc_b_o,
  output cmp_kind_e         kind_o,
  output logic              bad_op_o
);
  logic [DATA_W-1:0] nxt_a, nxt_b;
  cmp_kind_e         nxt_kind;
  logic              load;

  always_comb begin
    nxt_a    = upd_op1_i;
    nxt_b    = upd_op2_i;
    nxt_kind = KIND_ARITH;
    load     = upd_valid_i;
    bad_op_o = 1'b0;
    unique case (upd_op_i)
      OP_SUB, OP_CMP: ;
      OP_RSB: begin
        nxt_a = upd_op2_i;
        nxt_b = upd_op1_i;
      end
      OP_ADD: begin
        nxt_a = upd_op2_i;
        nxt_b = -upd_op1_i;
      end
      OP_CMN: nxt_b = -upd_op2_i;
      OP_TST: nxt_kind = KIND_AND;
      OP_TEQ: nxt_kind = KIND_XOR;
      OP_ADC, OP_SBC, OP_RSC: begin
        load     = 1'b0;
        bad_op_o = upd_valid_i;
      end
      default: begin // logical ops, move and move-not
        nxt_a = upd_res_i;
        nxt_b = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_a_o <= '0;
      cc_b_o <= '0;
      kind_o <= KIND_ARITH;
    end else if (load) begin
      cc_a_o <= nxt_a;
      cc_b_o <= nxt_b;
      kind_o <= nxt_kind;
    end
  end
endmodule

// File: rtl/dfc_eval.sv
module dfc_eval
  import dfc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [COND_W-1:0] cond_i,
  input  logic [DATA_W-1:0] cc_a_i,
  input  logic [DATA_W-1:0] cc_b_i,
  input  cmp_kind_e         kind_i,
  output logic              exec_o,
  output logic              trap_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] diff, tval;
  logic eq, ltu, lts, dneg, tzero, tneg;

  assign diff  = cc_a_i - cc_b_i;
  assign eq    = (cc_a_i == cc_b_i);
  assign ltu   = (cc_a_i < cc_b_i);
  assign lts   = ($signed(cc_a_i) < $signed(cc_b_i));
  assign dneg  = diff[MSB];
  assign tval  = (kind_i == KIND_XOR) ? (cc_a_i ^ cc_b_i) : (cc_a_i & cc_b_i);
  assign tzero = (tval == '0);
  assign tneg  = tval[MSB];

  always_comb begin
    exec_o = 1'b0;
    trap_o = 1'b0;
    if (cond_i == 4'd14) begin
      exec_o = 1'b1;
    end else if (cond_i == 4'd15) begin
      exec_o = 1'b0;
    end else if (kind_i == KIND_ARITH) begin
      case (cond_i)
        4'd0:    exec_o = eq;
        4'd1:    exec_o = !eq;
        4'd2:    exec_o = !ltu;
        4'd3:    exec_o = ltu;
        4'd4:    exec_o = dneg;
        4'd5:    exec_o = !dneg;
        4'd8:    exec_o = !ltu && !eq;
        4'd9:    exec_o = ltu || eq;
        4'd10:   exec_o = !lts;
        4'd11:   exec_o = lts;
        4'd12:   exec_o = !lts && !eq;
        4'd13:   exec_o = lts || eq;
        default: trap_o = 1'b1; // overflow codes
      endcase
    end else begin
      case (cond_i)
        4'd0:    exec_o = tzero;
        4'd1:    exec_o = !tzero;
        4'd4:    exec_o = tneg;
        4'd5:    exec_o = !tneg;
        default: trap_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dfc_cond_unit.sv
module dfc_cond_unit
  import dfc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int COND_LSB = 28
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               upd_valid_i,
  input  logic [3:0]         upd_op_i,
  input  logic [DATA_W-1:0]  upd_op1_i,
  input  logic [DATA_W-1:0]  upd_op2_i,
  input  logic [DATA_W-1:0]  upd_res_i,
  output logic               exec_o,
  output logic               trap_o,
  output logic               upd_trap_o
);
  logic [COND_W-1:0] cond;
  logic [DATA_W-1:0] cc_a, cc_b;
  cmp_kind_e         kind;
  logic              instr_unused;

  assign cond         = instr_i[COND_LSB +: COND_W];
  assign instr_unused = ^instr_i[COND_LSB-1:0];

  dfc_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .upd_valid_i (upd_valid_i),
    .upd_op_i    (upd_op_i),
    .upd_op1_i   (upd_op1_i),
    .upd_op2_i   (upd_op2_i),
    .upd_res_i   (upd_res_i),
    .cc_a_o      (cc_a),
    .cc_b_o      (cc_b),
    .kind_o      (kind),
    .bad_op_o    (upd_trap_o)
  );

  dfc_eval #(.DATA_W(DATA_W)) u_eval (
    .cond_i (cond),
    .cc_a_i (cc_a),
    .cc_b_i (cc_b),
    .kind_i (kind),
    .exec_o (exec_o),
    .trap_o (trap_o)
  );
endmodule

// File: rtl/dfc_cond_unit_chk.sv
module dfc_cond_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int COND_LSB = 28
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [INSTR_W-1:0] instr_i,
  input logic               upd_valid_i,
  input logic [3:0]         upd_op_i,
  input logic [DATA_W-1:0]  upd_op1_i,
  input logic [DATA_W-1:0]  upd_op2_i,
  input logic               exec_o,
  input logic               trap_o,
  input logic               upd_trap_o
);
  logic [3:0] cnd;
  assign cnd = instr_i[COND_LSB +: 4];

  assert_trap_no_exec_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !exec_o);

  assert_always_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnd == 4'd14) |-> (exec_o && !trap_o));

  assert_never_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnd == 4'd15) |-> (!exec_o && !trap_o));

  assert_carry_op_trap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_op_i >= 4'd5 && upd_op_i <= 4'd7) |-> upd_trap_o);

  assert_no_trap_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |-> !upd_trap_o);

  assert_sub_equal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_op_i == 4'd2) |=>
      (cnd != 4'd0 || exec_o == ($past(upd_op1_i) == $past(upd_op2_i))));

  assert_overflow_trap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_op_i == 4'd10) |=> (cnd != 4'd6 || trap_o));

  assert_test_kind_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_op_i == 4'd8) |=> (cnd != 4'd2 || trap_o));
endmodule

bind dfc_cond_unit dfc_cond_unit_chk #(
  .DATA_W(DATA_W), .INSTR_W(INSTR_W), .COND_LSB(COND_LSB)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_i     (instr_i),
  .upd_valid_i (upd_valid_i),
  .upd_op_i    (upd_op_i),
  .upd_op1_i   (upd_op1_i),
  .upd_op2_i   (upd_op2_i),
  .exec_o      (exec_o),
  .trap_o      (trap_o),
  .upd_trap_o  (upd_trap_o)
);

// File: tb/dfc_cond_unit_test.sv
module dfc_cond_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic        upd_valid_i = 1'b0;
  logic [3:0]  upd_op_i = '0;
  logic [31:0] upd_op1_i = '0, upd_op2_i = '0, upd_res_i = '0;
  logic        exec_o, trap_o, upd_trap_o;

  int checks = 0;
  int errors = 0;

  // bench model of the saved state: kind 0 arith, 1 xor, 2 and
  int          m_kind = 0;
  logic [31:0] m_a = '0, m_b = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dfc_cond_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i),
    .upd_valid_i(upd_valid_i), .upd_op_i(upd_op_i),
    .upd_op1_i(upd_op1_i), .upd_op2_i(upd_op2_i), .upd_res_i(upd_res_i),
    .exec_o(exec_o), .trap_o(trap_o), .upd_trap_o(upd_trap_o)
  );

  // returns {trap, exec}
  function automatic logic [1:0] expect_of(int kind, logic [31:0] a, logic [31:0] b, int c);
    logic [31:0] d, t;
    d = a - b;
    if (c == 14) return 2'b01;
    if (c == 15) return 2'b00;
    if (kind == 0) begin
      case (c)
        0:  return {1'b0, a == b};
        1:  return {1'b0, a != b};
        2:  return {1'b0, a >= b};
        3:  return {1'b0, a < b};
        4:  return {1'b0, d[31]};
        5:  return {1'b0, !d[31]};
        8:  return {1'b0, a > b};
        9:  return {1'b0, a <= b};
        10: return {1'b0, $signed(a) >= $signed(b)};
        11: return {1'b0, $signed(a) < $signed(b)};
        12: return {1'b0, $signed(a) > $signed(b)};
        13: return {1'b0, $signed(a) <= $signed(b)};
        default: return 2'b10;
      endcase
    end
    t = (kind == 1) ? (a ^ b) : (a & b);
    case (c)
      0: return {1'b0, t == 0};
      1: return {1'b0, t != 0};
      4: return {1'b0, t[31]};
      5: return {1'b0, !t[31]};
      default: return 2'b10;
    endcase
  endfunction

  function automatic string cond_tag(int kind, int c);
    if (c >= 14) return "R5";
    if (kind != 0) return "R7";
    if (c == 6 || c == 7) return "R6";
    if (c == 4 || c == 5 || c >= 10) return "R4";
    return "R3";
  endfunction

  function automatic string op_tag(int op);
    case (op)
      2, 3, 10: return "R8";
      4, 11:    return "R9";
      8, 9:     return "R7";
      5, 6, 7:  return "R11";
      default:  return "R10";
    endcase
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom % 6)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7fff_ffff;
      3: return 32'hffff_ffff;
      4: return $urandom % 4;
      default: return $urandom;
    endcase
  endfunction

  task automatic check_cond(int c, logic [27:0] low, string tag);
    logic [1:0] e;
    @(negedge clk_i);
    instr_i = {c[3:0], low};
    #1;
    e = expect_of(m_kind, m_a, m_b, c);
    checks++;
    if ({trap_o, exec_o} !== e) begin
      errors++;
      $display("FAIL %s %s cond=%0d trap/exec actual=%b expected=%b (a=%h b=%h kind=%0d)",
               tag, cond_tag(m_kind, c), c, {trap_o, exec_o}, e, m_a, m_b, m_kind);
    end
  endtask

  task automatic sweep(string tag);
    for (int c = 0; c < 16; c++) check_cond(c, 28'($urandom), tag);
  endtask

  task automatic update(int op, logic [31:0] o1, logic [31:0] o2, logic [31:0] r);
    logic bad;
    @(negedge clk_i);
    upd_valid_i = 1'b1;
    upd_op_i    = op[3:0];
    upd_op1_i   = o1;
    upd_op2_i   = o2;
    upd_res_i   = r;
    #1;
    bad = (op >= 5 && op <= 7);
    checks++;
    if (upd_trap_o !== bad) begin
      errors++;
      $display("FAIL R11 op=%0d upd_trap actual=%b expected=%b", op, upd_trap_o, bad);
    end
    @(posedge clk_i);
    case (op)
      2, 10: begin m_kind = 0; m_a = o1; m_b = o2; end
      3:     begin m_kind = 0; m_a = o2; m_b = o1; end
      4:     begin m_kind = 0; m_a = o2; m_b = -o1; end
      11:    begin m_kind = 0; m_a = o1; m_b = -o2; end
      8:     begin m_kind = 2; m_a = o1; m_b = o2; end
      9:     begin m_kind = 1; m_a = o1; m_b = o2; end
      5, 6, 7: ;
      default: begin m_kind = 0; m_a = r; m_b = '0; end
    endcase
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    upd_op_i    = 4'($urandom);
    #1;
    checks++;
    if (upd_trap_o !== 1'b0) begin
      errors++;
      $display("FAIL R11 idle upd_trap actual=%b expected=0", upd_trap_o);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    int op;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R2: reset state
    sweep("R2");

    // R1: lower bits must not matter
    check_cond(15, 28'hfff_ffff, "R1");
    check_cond(14, 28'h000_0000, "R1");
    check_cond(0, 28'hfff_ffff, "R1");

    // directed corners
    update(10, 32'h7fff_ffff, 32'h8000_0000, 32'h0); sweep("R8 R12");
    update(3, 32'h5, 32'h5, 32'h0);                   sweep("R8");
    update(4, 32'h1, 32'hffff_ffff, 32'h0);           sweep("R9");
    update(11, 32'h8000_0000, 32'h8000_0000, 32'h0);  sweep("R9");
    update(13, 32'h0, 32'h0, 32'h8000_0000);          sweep("R10");
    update(8, 32'hf0f0_f0f0, 32'h0f0f_0f0f, 32'h0);   sweep("R7");
    update(9, 32'h8000_0001, 32'h0000_0001, 32'h0);   sweep("R7");
    update(6, 32'h1, 32'h2, 32'h3);                   sweep("R11");

    // constrained random
    for (int i = 0; i < 350; i++) begin
      a  = pick();
      b  = ($urandom % 4 == 0) ? a : pick();
      op = $urandom % 16;
      update(op, a, b, pick());
      sweep({op_tag(op), " R12"});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule